// File: doc/BRIEF.md
# Selection Scheduler with Per-Target Lockout

This block sits in a parallel-bus initiator and chooses which command slot goes to the bus next. Three sources compete: a target that is reconnecting on one of two channels, a linked list of slots waiting to be selected (a slot whose selection lost to a reconnecting target stays on this list and is tried again), and an external first-in first-out queue of newly posted slot indices. The list is threaded through a next-pointer byte kept for every slot. The value 0xFF marks the end of the list, so slot indices 0x00 to 0xFE are usable.

For every target, each channel keeps a bit that says an untagged command is in flight. A slot popped from the input queue whose target bit is already set is written back into the queue and is not started. A slot that is started from the input queue is placed at the front of the waiting list. A selection-done input then removes the slot from the list. A retry input leaves the slot on the list so that it is picked again. A completion port clears the target bit of an untagged command.

The bus protocol and data movement belong to other blocks. This block only issues one-cycle start pulses and then waits for the outcome.

Top module: `sel_sched`

## Requirements
- R1: After reset no start, reconnect, pop or push output is active. The waiting list is empty, so `slot_rd_idx` shows 0xFF. Every target busy bit is clear.
- R2: When idle, a pending reconnection wins first. A non-empty waiting list comes second. A pop from the input queue comes last and happens only when `qin_count` is nonzero.
- R3: With two channels, the channel other than the one used last is checked for a reconnection first. The last-used channel is 0 after reset.
- R4: The head of the waiting list is started without any busy check, and `start_slot` equals the head index.
- R5: Selection-done after a list start moves the head to that slot's next pointer and resets the slot's next pointer to 0xFF. After a reconnection, selection-done leaves the list untouched.
- R6: A retry after a start leaves the list unchanged, and the same slot is started again on the next pick.
- R7: A popped index appears on `slot_rd_idx` in the following cycle. The channel is B when target byte bit 7 or bit 3 is set and A otherwise. The target ID in bits 6:4 selects one of eight busy bits. A started popped slot goes to the front of the waiting list.
- R8: If the popped slot's target bit is set, the same index is pushed back into the input queue in the cycle after the pop, and no start occurs. A target never has two untagged commands started from the queue at the same time.
- R9: Starting an untagged slot (`slot_tagged` = 0, which is bit 5 of the control byte) sets its target bit. Starting a tagged slot does not.
- R10: A completion with `done_tagged` = 0 clears the target bit given by `done_tgt`. A tagged completion leaves every bit unchanged.
- R11: `start_valid` and `resel_go` last exactly one cycle. After either one, nothing is picked until `sel_done` or `sel_retry`.
- R12: Slots appended through `enq_valid` are started in the order in which they were appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resel_det | input | 2 | Reconnection detected, one bit per channel (bit 1 = B) |
| resel_go | output | 1 | One-cycle pulse: reconnection accepted |
| resel_chan | output | 1 | Channel of the accepted reconnection |
| qin_count | input | 8 | Number of entries in the input queue |
| qin_data | input | 8 | Front entry of the input queue (valid when count nonzero) |
| qin_pop | output | 1 | Remove the front entry of the input queue |
| qin_push | output | 1 | Write `qin_push_data` back into the input queue |
| qin_push_data | output | 8 | Slot index being requeued |
| slot_rd_idx | output | 8 | Slot whose control and target fields are presented |
| slot_tagged | input | 1 | Tagged flag (control bit 5) of the addressed slot |
| slot_tgt | input | 5 | Target byte bits 7:3 of the addressed slot |
| enq_valid | input | 1 | Append `enq_slot` to the tail of the waiting list |
| enq_slot | input | 8 | Slot index to append |
| start_valid | output | 1 | One-cycle pulse: begin selection of `start_slot` |
| start_slot | output | 8 | Slot being selected |
| sel_done | input | 1 | Selection (or reconnection) won |
| sel_retry | input | 1 | Selection lost; try again later |
| done_valid | input | 1 | A command has completed |
| done_tagged | input | 1 | Tagged flag of the completed command |
| done_tgt | input | 5 | Target byte bits 7:3 of the completed command |

## Verification
Properties inside the design check on every cycle that at most one of start, reconnect, pop and push is active at a time, and that start pulses last one cycle and are followed by a quiet cycle. They also check that a requeue returns exactly the index popped one cycle earlier, that a busy bit is set only while clear and is gone after an untagged completion, and that the list head and tail agree on emptiness while the tail always ends the chain. Only the bench's scenarios can show the rest: the ordering among the three sources, the fairness between channels, the order in which appended slots are started, the retry of a lost slot, and the fact that the lockout stops a second untagged command for the same target. The bench does this by running its own model of queue, list and bitmaps against the ports under directed and random traffic.

// File: rtl/sel_pkg.sv
package sel_pkg;

    typedef logic [7:0] ptr_t;
    localparam ptr_t PTR_NULL = 8'hFF;

    // target byte without LUN: bit 7 and bit 3 pick channel, 6:4 is the ID
    typedef logic [7:3] tgt_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_WAIT  = 2'd2
    } sched_st_e;

    typedef struct packed {
        sched_st_e st;
        ptr_t      slot;
        logic      chan;
        logic      via_resel;
    } sched_t;

    function automatic logic chan_sel(tgt_t t);
        return t[7] | t[3];
    endfunction

    function automatic logic [7:0] id_mask(tgt_t t);
        return 8'b1 << t[6:4];
    endfunction

endpackage

// File: rtl/sel_busy_map.sv
module sel_busy_map
    import sel_pkg::*;
#(
    parameter int NCHAN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  tgt_t q_tgt,
    output logic q_busy,
    input  logic set_v,
    input  tgt_t set_tgt,
    input  logic clr_v,
    input  tgt_t clr_tgt
);
    localparam int CH_W = (NCHAN > 1) ? $clog2(NCHAN) : 1;

    typedef struct packed {
        logic [NCHAN-1:0][7:0] map;
    } bm_t;

    bm_t bm_q, bm_d;
    logic [CH_W-1:0] q_ci, set_ci, clr_ci;

    assign q_ci   = (NCHAN > 1) ? CH_W'(chan_sel(q_tgt))   : '0;
    assign set_ci = (NCHAN > 1) ? CH_W'(chan_sel(set_tgt)) : '0;
    assign clr_ci = (NCHAN > 1) ? CH_W'(chan_sel(clr_tgt)) : '0;

    assign q_busy = |(bm_q.map[q_ci] & id_mask(q_tgt));

    always_comb begin
        bm_d = bm_q;
        if (clr_v) bm_d.map[clr_ci] = bm_d.map[clr_ci] & ~id_mask(clr_tgt);
        if (set_v) bm_d.map[set_ci] = bm_d.map[set_ci] | id_mask(set_tgt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bm_q <= '0;
        else        bm_q <= bm_d;
    end

    // R8: a target bit is only ever set while it is clear
    p_set_only_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_v |-> ((bm_q.map[set_ci] & id_mask(set_tgt)) == 8'h00));

    // R10: an untagged completion leaves its bit clear in the next cycle
    p_clear_takes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v && !set_v) |=> ((bm_q.map[$past(clr_ci)] & id_mask($past(clr_tgt))) == 8'h00));

endmodule

// File: rtl/sel_wait_list.sv
module sel_wait_list
    import sel_pkg::*;
#(
    parameter int NSLOTS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic front_v,
    input  ptr_t front_slot,
    input  logic pop_v,
    input  logic app_v,
    input  ptr_t app_slot,
    output ptr_t head
);
    localparam int IDX_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;

    typedef struct packed {
        ptr_t                   head;
        ptr_t                   tail;
        logic [NSLOTS-1:0][7:0] nxt;
    } wl_t;

    wl_t wl_q, wl_d;
    logic [IDX_W-1:0] h_i, f_i, a_i, t_i;

    assign head = wl_q.head;
    assign h_i  = wl_q.head[IDX_W-1:0];
    assign f_i  = front_slot[IDX_W-1:0];
    assign a_i  = app_slot[IDX_W-1:0];

    always_comb begin
        wl_d = wl_q;
        t_i  = '0;
        // remove the head after a won selection
        if (pop_v && wl_q.head != PTR_NULL) begin
            wl_d.head     = wl_q.nxt[h_i];
            wl_d.nxt[h_i] = PTR_NULL;
            if (wl_q.nxt[h_i] == PTR_NULL) wl_d.tail = PTR_NULL;
        end
        // a freshly popped slot goes in front
        if (front_v) begin
            wl_d.nxt[f_i] = wl_d.head;
            if (wl_d.head == PTR_NULL) wl_d.tail = front_slot;
            wl_d.head = front_slot;
        end
        // host appends at the tail
        if (app_v) begin
            t_i = wl_d.tail[IDX_W-1:0];
            if (wl_d.tail == PTR_NULL) wl_d.head = app_slot;
            else                       wl_d.nxt[t_i] = app_slot;
            wl_d.tail     = app_slot;
            wl_d.nxt[a_i] = PTR_NULL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wl_q.head <= PTR_NULL;
            wl_q.tail <= PTR_NULL;
            wl_q.nxt  <= '1;
        end else begin
            wl_q <= wl_d;
        end
    end

    // R5: head and tail agree on whether the list is empty
    p_ends_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wl_q.head == PTR_NULL) == (wl_q.tail == PTR_NULL));

    // R12: the tail always terminates the chain
    p_tail_terminal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wl_q.tail != PTR_NULL) |-> (wl_q.nxt[wl_q.tail[IDX_W-1:0]] == PTR_NULL));

    // R5: a lone removal advances head to the old next pointer
    p_pop_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_v && !front_v && !app_v && wl_q.head != PTR_NULL)
        |=> (wl_q.head == $past(wl_q.nxt[h_i])));

endmodule

// File: rtl/sel_sched.sv
module sel_sched
    import sel_pkg::*;
#(
    parameter int NSLOTS = 16,
    parameter int CNT_W  = 8,
    parameter int NCHAN  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       resel_det,
    output logic             resel_go,
    output logic             resel_chan,
    input  logic [CNT_W-1:0] qin_count,
    input  logic [7:0]       qin_data,
    output logic             qin_pop,
    output logic             qin_push,
    output logic [7:0]       qin_push_data,
    output logic [7:0]       slot_rd_idx,
    input  logic             slot_tagged,
    input  logic [7:3]       slot_tgt,
    input  logic             enq_valid,
    input  logic [7:0]       enq_slot,
    output logic             start_valid,
    output logic [7:0]       start_slot,
    input  logic             sel_done,
    input  logic             sel_retry,
    input  logic             done_valid,
    input  logic             done_tagged,
    input  logic [7:3]       done_tgt
);
    sched_t q, d;
    ptr_t   head;
    logic   tgt_busy;
    logic   front_v, pop_v, set_v;
    logic   resel_hit, resel_pick;

    // reconnection pick: dual channel checks the other side first
    if (NCHAN > 1) begin : g_dual
        always_comb begin
            resel_hit  = 1'b0;
            resel_pick = 1'b0;
            if (resel_det[~q.chan]) begin
                resel_hit  = 1'b1;
                resel_pick = ~q.chan;
            end else if (resel_det[q.chan]) begin
                resel_hit  = 1'b1;
                resel_pick = q.chan;
            end
        end
    end else begin : g_single
        assign resel_hit  = resel_det[0];
        assign resel_pick = 1'b0;
    end

    always_comb begin
        d             = q;
        resel_go      = 1'b0;
        resel_chan    = 1'b0;
        qin_pop       = 1'b0;
        qin_push      = 1'b0;
        qin_push_data = '0;
        start_valid   = 1'b0;
        start_slot    = '0;
        front_v       = 1'b0;
        pop_v         = 1'b0;
        set_v         = 1'b0;
        slot_rd_idx   = (q.st == ST_CHECK) ? q.slot : head;
        case (q.st)
            ST_IDLE: begin
                if (resel_hit) begin
                    resel_go    = 1'b1;
                    resel_chan  = resel_pick;
                    d.st        = ST_WAIT;
                    d.via_resel = 1'b1;
                    d.chan      = resel_pick;
                end else if (head != PTR_NULL) begin
                    start_valid = 1'b1;
                    start_slot  = head;
                    d.st        = ST_WAIT;
                    d.via_resel = 1'b0;
                    d.chan      = chan_sel(slot_tgt);
                end else if (qin_count != '0) begin
                    qin_pop = 1'b1;
                    d.slot  = qin_data;
                    d.st    = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (tgt_busy) begin
                    qin_push      = 1'b1;
                    qin_push_data = q.slot;
                    d.st          = ST_IDLE;
                end else begin
                    start_valid = 1'b1;
                    start_slot  = q.slot;
                    front_v     = 1'b1;
                    set_v       = !slot_tagged;
                    d.st        = ST_WAIT;
                    d.via_resel = 1'b0;
                    d.chan      = chan_sel(slot_tgt);
                end
            end
            ST_WAIT: begin
                if (sel_done) begin
                    pop_v = !q.via_resel;
                    d.st  = ST_IDLE;
                end else if (sel_retry) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.slot      <= PTR_NULL;
            q.chan      <= 1'b0;
            q.via_resel <= 1'b0;
        end else begin
            q <= d;
        end
    end

    sel_busy_map #(.NCHAN(NCHAN)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .q_tgt   (slot_tgt),
        .q_busy  (tgt_busy),
        .set_v   (set_v),
        .set_tgt (slot_tgt),
        .clr_v   (done_valid && !done_tagged),
        .clr_tgt (done_tgt)
    );

    sel_wait_list #(.NSLOTS(NSLOTS)) u_list (
        .clk        (clk),
        .rst_n      (rst_n),
        .front_v    (front_v),
        .front_slot (q.slot),
        .pop_v      (pop_v),
        .app_v      (enq_valid),
        .app_slot   (enq_slot),
        .head       (head)
    );

    // R2: at most one action per cycle
    p_one_action_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_valid, resel_go, qin_pop, qin_push}));

    // R7: pops only from a non-empty queue
    p_pop_has_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        qin_pop |-> (qin_count != '0));

    // R8: a requeue returns the index popped one cycle earlier
    p_push_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
        qin_push |-> ($past(qin_pop) && qin_push_data == $past(qin_data)));

    // R11: start pulses are single cycle and followed by silence
    p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid || resel_go) |=> !(start_valid || resel_go || qin_pop));

endmodule

// File: tb/sel_sched_tb.sv
module sel_sched_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] resel_det;
    logic       resel_go, resel_chan;
    logic [7:0] qin_count, qin_data;
    logic       qin_pop, qin_push;
    logic [7:0] qin_push_data, slot_rd_idx;
    logic       slot_tagged;
    logic [7:3] slot_tgt;
    logic       enq_valid;
    logic [7:0] enq_slot;
    logic       start_valid;
    logic [7:0] start_slot;
    logic       sel_done, sel_retry, done_valid, done_tagged;
    logic [7:3] done_tgt;

    always #10 clk = ~clk;

    sel_sched u_dut (.*);

    // bench model
    logic [7:0] mtgt [16];
    logic       mtag [16];
    logic [7:0] fifo_q[$];
    logic [7:0] list_q[$];
    logic [7:0] run_q[$];
    logic [7:0] free_q[$];
    logic [15:0] mbusy;
    int         ucnt [16];
    int         mmode;
    logic [7:0] mchk;
    logic       mcur, mkind;
    int         tests = 0, fails = 0;
    bit         finished = 0;

    always_comb begin
        slot_tgt    = (slot_rd_idx < 8'd16) ? mtgt[slot_rd_idx[3:0]][7:3] : 5'd0;
        slot_tagged = (slot_rd_idx < 8'd16) ? mtag[slot_rd_idx[3:0]] : 1'b0;
    end

    function automatic logic chan8(logic [7:0] t);
        return t[7] | t[3];
    endfunction

    task automatic refresh_fifo();
        qin_count = 8'(fifo_q.size());
        qin_data  = (fifo_q.size() > 0) ? fifo_q[0] : 8'h00;
    endtask

    task automatic fifo_add(input logic [7:0] s);
        fifo_q.push_back(s);
        refresh_fifo();
    endtask

    task automatic step(input string tag, input logic [1:0] rs, input logic ev,
                        input logic [7:0] es, input logic sd, input logic sr,
                        input logic dv, input logic [7:0] ds);
        logic e_st, e_pop, e_push, e_rgo, e_rch;
        logic [7:0] e_slot, e_pd;
        int n_mode;
        logic [7:0] n_chk;
        logic n_cur, n_kind;
        logic do_fpop, do_fpush, do_lfront, do_lpop, do_set;
        logic [3:0] key;
        logic [21:0] act, exp_v;
        resel_det = rs; enq_valid = ev; enq_slot = es; sel_done = sd; sel_retry = sr;
        done_valid = dv; done_tagged = mtag[ds[3:0]]; done_tgt = mtgt[ds[3:0]][7:3];
        e_st = 0; e_pop = 0; e_push = 0; e_rgo = 0; e_rch = 0; e_slot = 0; e_pd = 0;
        n_mode = mmode; n_chk = mchk; n_cur = mcur; n_kind = mkind;
        do_fpop = 0; do_fpush = 0; do_lfront = 0; do_lpop = 0; do_set = 0; key = 0;
        @(negedge clk);
        case (mmode)
            0: begin
                if (rs != 2'b00) begin
                    e_rgo = 1;
                    e_rch = rs[~mcur] ? ~mcur : mcur;
                    n_mode = 2; n_kind = 1; n_cur = e_rch;
                end else if (list_q.size() > 0) begin
                    e_st = 1; e_slot = list_q[0];
                    n_mode = 2; n_kind = 0; n_cur = chan8(mtgt[e_slot[3:0]]);
                end else if (fifo_q.size() > 0) begin
                    e_pop = 1; do_fpop = 1; n_chk = fifo_q[0]; n_mode = 1;
                end
            end
            1: begin
                key = {chan8(mtgt[mchk[3:0]]), mtgt[mchk[3:0]][6:4]};
                if (mbusy[key]) begin
                    e_push = 1; e_pd = mchk; do_fpush = 1; n_mode = 0;
                end else begin
                    e_st = 1; e_slot = mchk; do_lfront = 1; n_mode = 2; n_kind = 0;
                    n_cur = key[3];
                    if (!mtag[mchk[3:0]]) begin
                        do_set = 1;
                        tests++;
                        if (ucnt[key] != 0) begin
                            fails++;
                            $display("FAIL R8 second untagged start on target %0h: in flight %0d expected 0",
                                     key, ucnt[key]);
                        end
                    end
                end
            end
            default: begin
                if (sd) begin do_lpop = !mkind; n_mode = 0; end
                else if (sr) n_mode = 0;
            end
        endcase
        act   = {start_valid, start_slot, qin_pop, qin_push, qin_push_data, resel_go, resel_chan};
        exp_v = {e_st, e_slot, e_pop, e_push, e_pd, e_rgo, e_rch};
        tests++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s outputs {start,slot,pop,push,pdata,rgo,rch} actual %h expected %h",
                     tag, act, exp_v);
        end
        @(posedge clk); #1;
        if (do_fpop)   void'(fifo_q.pop_front());
        if (do_fpush)  fifo_q.push_back(mchk);
        if (do_lpop)   run_q.push_back(list_q.pop_front());
        if (do_lfront) list_q.push_front(mchk);
        if (ev)        list_q.push_back(es);
        if (dv) begin
            if (!mtag[ds[3:0]]) begin
                mbusy[{chan8(mtgt[ds[3:0]]), mtgt[ds[3:0]][6:4]}] = 1'b0;
                ucnt[{chan8(mtgt[ds[3:0]]), mtgt[ds[3:0]][6:4]}]--;
            end
            foreach (run_q[i]) if (run_q[i] == ds) begin run_q.delete(i); break; end
            free_q.push_back(ds);
        end
        if (do_set) begin mbusy[key] = 1'b1; ucnt[key]++; end
        mmode = n_mode; mchk = n_chk; mcur = n_cur; mkind = n_kind;
        resel_det = 0; enq_valid = 0; sel_done = 0; sel_retry = 0; done_valid = 0;
        refresh_fifo();
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 2'b00, 0, 8'h0, 0, 0, 0, 8'h0);
    endtask

    task automatic sdone(input string tag);
        step(tag, 2'b00, 0, 8'h0, 1, 0, 0, 8'h0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual hung expected finish");
        finish_run();
    end

    initial begin
        int r;
        logic [1:0] rs;
        logic ev, sd, sr, dv;
        logic [7:0] es, ds;
        r = $urandom(32'h5EED);
        for (int i = 0; i < 16; i++) begin mtgt[i] = 8'h00; mtag[i] = 1'b0; ucnt[i] = 0; end
        mbusy = '0; mmode = 0; mchk = 8'hFF; mcur = 0; mkind = 0;
        resel_det = 0; enq_valid = 0; enq_slot = 0; sel_done = 0; sel_retry = 0;
        done_valid = 0; done_tagged = 0; done_tgt = 0;
        refresh_fifo();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        @(negedge clk);
        tests++;
        if ({start_valid, resel_go, qin_pop, qin_push} !== 4'b0 || slot_rd_idx !== 8'hFF) begin
            fails++;
            $display("FAIL R1 reset outputs %b rd_idx %h expected 0000 ff",
                     {start_valid, resel_go, qin_pop, qin_push}, slot_rd_idx);
        end
        @(posedge clk); #1;
        idle("R1", 2);

        mtgt[1] = 8'h30; mtag[1] = 0;  mtgt[2] = 8'h31; mtag[2] = 0;
        mtgt[3] = 8'h38; mtag[3] = 0;  mtgt[4] = 8'h50; mtag[4] = 1;
        mtgt[5] = 8'h52; mtag[5] = 0;  mtgt[6] = 8'h53; mtag[6] = 0;
        mtgt[7] = 8'h20; mtag[7] = 1;  mtgt[8] = 8'h21; mtag[8] = 1;
        mtgt[9] = 8'h34; mtag[9] = 1;  mtgt[10] = 8'h36; mtag[10] = 0;

        // R7 pop then start from the queue
        fifo_add(8'd1);
        idle("R7", 2);
        step("R11", 2'b11, 0, 8'h0, 0, 0, 0, 8'h0);
        sdone("R5");
        // R8 same target on channel A is blocked, channel B is not
        fifo_add(8'd2);
        idle("R8", 2);
        fifo_add(8'd3);
        idle("R8", 4);
        sdone("R7");
        // R10 untagged completion frees target 3 on A
        step("R10", 2'b00, 0, 8'h0, 0, 0, 1, 8'd1);
        idle("R10", 1);
        sdone("R10");
        // R9 tagged does not lock, untagged does
        fifo_add(8'd4);
        idle("R9", 2);
        sdone("R9");
        fifo_add(8'd5);
        idle("R9", 2);
        sdone("R9");
        fifo_add(8'd6);
        idle("R8", 2);
        step("R10", 2'b00, 0, 8'h0, 0, 0, 1, 8'd4);
        idle("R10", 3);
        step("R10", 2'b00, 0, 8'h0, 0, 0, 1, 8'd5);
        idle("R10", 3);
        sdone("R10");
        // R3 fairness between channels
        step("R3", 2'b11, 0, 8'h0, 0, 0, 0, 8'h0);
        sdone("R5");
        step("R3", 2'b11, 0, 8'h0, 0, 0, 0, 8'h0);
        sdone("R5");
        step("R3", 2'b01, 0, 8'h0, 0, 0, 0, 8'h0);
        sdone("R5");
        // R12 appended order, R6 retry
        step("R12", 2'b00, 1, 8'd7, 0, 0, 0, 8'h0);
        step("R12", 2'b00, 1, 8'd8, 0, 0, 0, 8'h0);
        step("R6", 2'b00, 0, 8'h0, 0, 1, 0, 8'h0);
        idle("R6", 1);
        sdone("R5");
        idle("R12", 1);
        sdone("R12");
        // R4 list head beats queue and skips the busy check
        fifo_add(8'd10);
        step("R2", 2'b00, 1, 8'd9, 0, 0, 0, 8'h0);
        idle("R8", 1);
        idle("R4", 1);
        sdone("R4");
        // R2 reconnection beats a non-empty list
        step("R2", 2'b00, 1, 8'd11, 0, 0, 0, 8'h0);
        mtgt[11] = 8'h40; mtag[11] = 1;
        step("R2", 2'b10, 0, 8'h0, 0, 0, 0, 8'h0);
        sdone("R5");
        idle("R2", 1);
        sdone("R2");

        foreach (free_q[i]) free_q.delete(i);
        free_q.push_back(8'd0); free_q.push_back(8'd12); free_q.push_back(8'd13);
        free_q.push_back(8'd14); free_q.push_back(8'd15);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            rs = ($urandom % 10 == 0) ? 2'($urandom) : 2'b00;
            sd = 0; sr = 0; dv = 0; ev = 0; es = 0; ds = 0;
            if (mmode == 2) begin
                r = $urandom % 4;
                sd = (r == 0); sr = (r == 1);
            end
            if (run_q.size() > 0 && $urandom % 3 == 0) begin
                dv = 1; ds = run_q[$urandom % run_q.size()];
            end
            if (free_q.size() > 0 && $urandom % 4 == 0) begin
                es = free_q.pop_front();
                mtgt[es[3:0]] = {1'($urandom), 1'b0, 2'($urandom), 1'($urandom), 3'($urandom)};
                if ($urandom % 4 == 0) begin
                    mtag[es[3:0]] = 1; ev = 1;
                end else begin
                    mtag[es[3:0]] = 1'($urandom);
                    fifo_add(es);
                end
            end
            step("R2", rs, ev, es, sd, sr, dv, ds);
        end
        finish_run();
    end
endmodule